// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block conditions one asynchronous pad input before it reaches the pin-status bit and the interrupt detector. The pad is first brought into the clock domain through a two-flop synchronizer. A filter stage then decides when the filtered level may follow the synchronized level. It times a period of stability against a slow real-time tick, which arrives as a single-cycle enable at about 32.768 kHz.

Software programs three things. The first is a 4-bit count. The second is a pair of timebase bits, which select one of four unit lengths measured in ticks. The third is a 2-bit mode. The mode either bypasses the filter, rejects short pulses of both polarities, or filters only one direction of change and lets the other through at once. A count of zero means no debounce is programmed, and the input then passes straight through.

Top module: `dbnc_filter`

## Requirements
- R1: A change on `pad_i` reaches `level_o` no sooner than three rising clock edges after it is driven. In pass-through conditions it arrives on exactly the third edge.
- R2: With `mode_i` = 2'b00 (bypass), `level_o` follows the synchronized input one clock later, whatever the count and timebase are.
- R3: With `cnt_i` = 0, `level_o` follows the synchronized input one clock later, in every mode.
- R4: With `mode_i` = 2'b01 (reject both), a rising or falling change reaches `level_o` on the clock that consumes the Nth tick during which the synchronized input differed from `level_o`. Here N is the threshold of R6.
- R5: If the synchronized input returns to the level of `level_o` for even one clock, any tick progress already made is discarded.
- R6: The threshold N is `cnt_i` × unit. The unit is selected by {`tb_large_i`,`tb_unit_i`}: 00 gives 2 ticks, 01 gives 8 ticks, 10 gives 512 ticks and 11 gives 2048 ticks.
- R7: With `mode_i` = 2'b10 (keep low pulses), a falling change passes one clock after synchronization, and a rising change is filtered as in R4.
- R8: With `mode_i` = 2'b11 (keep high pulses), a rising change passes one clock after synchronization, and a falling change is filtered as in R4.
- R9: While `rst_ni` is low, `level_o` and the synchronizer stages are 0.
- R10: In a filtering case, `level_o` does not change on a clock in which `tick_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle real-time tick enable |
| pad_i | input | 1 | Asynchronous pad level |
| cnt_i | input | 4 | Debounce count; 0 means no debounce |
| tb_unit_i | input | 1 | Timebase select, low bit |
| tb_large_i | input | 1 | Timebase select, high bit |
| mode_i | input | 2 | 00 bypass, 01 reject both, 10 keep low pulses, 11 keep high pulses |
| level_o | output | 1 | Filtered level |

## Verification
The assertions check on every cycle the cases where the output must copy the synchronized level at once. These are bypass, a zero count, and the unfiltered direction of the one-sided modes. They also check that any change of the output moves it to the synchronized value, and that it never moves without a tick while filtering. What they cannot show is the exact tick count before a filtered change, the loss of progress after a short pulse, and the four timebase lengths. The bench shows these by counting ticks in directed scenarios and by comparing against a cycle model under random pulses and configurations.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef enum logic [1:0] {
    FM_BYPASS    = 2'b00,
    FM_BOTH      = 2'b01,
    FM_KEEP_LOW  = 2'b10,
    FM_KEEP_HIGH = 2'b11
  } filt_mode_e;
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= 1'b0;
      else         stg_q[g] <= (g == 0) ? d_i : stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbnc_limit.sv
module dbnc_limit #(
  parameter int CNT_W     = 4,
  parameter int U0_LOG2   = 1,
  parameter int U1_LOG2   = 3,
  parameter int U2_LOG2   = 9,
  parameter int U3_LOG2   = 11,
  localparam int TMR_W    = CNT_W + U3_LOG2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             unit_i,
  input  logic             large_i,
  output logic [TMR_W-1:0] limit_o
);
  logic [TMR_W-1:0] base;
  assign base = TMR_W'(cnt_i);

  always_comb begin
    unique case ({large_i, unit_i})
      2'b00:   limit_o = base << U0_LOG2;
      2'b01:   limit_o = base << U1_LOG2;
      2'b10:   limit_o = base << U2_LOG2;
      default: limit_o = base << U3_LOG2;
    endcase
  end
endmodule

// File: rtl/dbnc_core.sv
module dbnc_core
  import dbnc_pkg::*;
#(
  parameter int TMR_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_i,
  input  filt_mode_e       mode_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             level_o
);
  logic             filt_q;
  logic [TMR_W-1:0] tmr_q;
  logic             pass_all, guarded, done;

  assign pass_all = (mode_i == FM_BYPASS) || (limit_i == '0);

  // direction of the pending change decides whether it is timed
  always_comb begin
    unique case (mode_i)
      FM_BOTH:      guarded = 1'b1;
      FM_KEEP_LOW:  guarded = sync_i;
      FM_KEEP_HIGH: guarded = !sync_i;
      default:      guarded = 1'b0;
    endcase
  end

  assign done = (tmr_q + 1'b1) >= limit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      tmr_q  <= '0;
    end else if (pass_all || (sync_i == filt_q) || !guarded) begin
      filt_q <= sync_i;
      tmr_q  <= '0;
    end else if (tick_i) begin
      if (done) begin
        filt_q <= sync_i;
        tmr_q  <= '0;
      end else begin
        tmr_q  <= tmr_q + 1'b1;
      end
    end
  end

  assign level_o = filt_q;
endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter
  import dbnc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int U0_LOG2     = 1,
  parameter int U1_LOG2     = 3,
  parameter int U2_LOG2     = 9,
  parameter int U3_LOG2     = 11,
  localparam int TMR_W      = CNT_W + U3_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pad_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tb_unit_i,
  input  logic             tb_large_i,
  input  logic [1:0]       mode_i,
  output logic             level_o
);
  logic             sync_q;
  logic [TMR_W-1:0] limit;

  dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync_q)
  );

  dbnc_limit #(
    .CNT_W(CNT_W), .U0_LOG2(U0_LOG2), .U1_LOG2(U1_LOG2),
    .U2_LOG2(U2_LOG2), .U3_LOG2(U3_LOG2)
  ) u_limit (
    .cnt_i  (cnt_i),
    .unit_i (tb_unit_i),
    .large_i(tb_large_i),
    .limit_o(limit)
  );

  dbnc_core #(.TMR_W(TMR_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .sync_i (sync_q),
    .mode_i (filt_mode_e'(mode_i)),
    .limit_i(limit),
    .level_o(level_o)
  );
endmodule

// File: rtl/dbnc_filter_chk.sv
module dbnc_filter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       mode_i,
  input logic             sync_lvl,
  input logic             level_o
);
  always_comb begin
    if (!rst_ni) begin
      p_reset_low_r9: assert (level_o == 1'b0);
    end
  end

  p_bypass_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (level_o == $past(sync_lvl)));

  p_zero_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> (level_o == $past(sync_lvl)));

  p_move_to_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o) |-> (level_o == $past(sync_lvl)));

  p_fall_fast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && cnt_i != '0 && !sync_lvl && level_o) |=> !level_o);

  p_rise_fast_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && cnt_i != '0 && sync_lvl && !level_o) |=> level_o);

  p_no_tick_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && cnt_i != '0 && !tick_i) |=> $stable(level_o));
endmodule

bind dbnc_filter dbnc_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .cnt_i   (cnt_i),
  .mode_i  (mode_i),
  .sync_lvl(sync_q),
  .level_o (level_o)
);

// File: tb/dbnc_filter_tb.sv
module dbnc_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       pad = 1'b0;
  logic [3:0] cnt = 4'd0;
  logic       unit_s = 1'b0;
  logic       large_s = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       level;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  dbnc_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pad_i(pad),
    .cnt_i(cnt), .tb_unit_i(unit_s), .tb_large_i(large_s),
    .mode_i(mode), .level_o(level)
  );

  function automatic int thresh(logic [3:0] c, logic lg, logic un);
    int u;
    u = lg ? (un ? 2048 : 512) : (un ? 8 : 2);
    return int'(c) * u;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model from the requirements
  logic m_s1, m_s2, m_lvl;
  int   m_ticks;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_lvl <= 0; m_ticks <= 0;
    end else begin
      m_s1 <= pad;
      m_s2 <= m_s1;
      if (mode == 2'b00 || cnt == 0 || m_s2 == m_lvl ||
          (mode == 2'b10 && !m_s2) || (mode == 2'b11 && m_s2)) begin
        m_lvl <= m_s2; m_ticks <= 0;
      end else if (tick) begin
        if (m_ticks + 1 >= thresh(cnt, large_s, unit_s)) begin
          m_lvl <= m_s2; m_ticks <= 0;
        end else m_ticks <= m_ticks + 1;
      end
    end
  end

  always @(negedge clk) if (cmp_en)
    check(level == m_lvl, "R4 R5 R7 R8 model", level, m_lvl);

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic give_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
    end
  endtask

  // drive new level, wait sync, count ticks until level_o takes it
  task automatic count_to_change(logic v, int max, output int n);
    n = 0;
    if (pad != v) begin pad = v; end
    cyc(3);
    while (level != v && n < max) begin
      tick = 1; @(negedge clk); tick = 0; n++;
      @(negedge clk);
    end
    if (level != v) n = -1;
  endtask

  task automatic setup(logic [3:0] c, logic lg, logic un, logic [1:0] md);
    cnt = c; large_s = lg; unit_s = un; mode = md;
  endtask

  initial begin
    int n;
    @(negedge clk);
    check(level == 1'b0, "R9", level, 0);
    pad = 1;
    cyc(2);
    check(level == 1'b0, "R9 under reset with pad high", level, 0);
    pad = 0;
    rst_n = 1;
    cyc(4);

    // R2 bypass: arrives on 3rd edge (R1)
    setup(4'd15, 1'b1, 1'b1, 2'b00);
    pad = 1; cyc(2);
    check(level == 1'b0, "R1 not before third edge", level, 0);
    cyc(1);
    check(level == 1'b1, "R2 bypass third edge", level, 1);
    pad = 0; cyc(3);
    check(level == 1'b0, "R2 bypass fall", level, 0);

    // R3 zero count in filtering mode
    setup(4'd0, 1'b0, 1'b1, 2'b01);
    pad = 1; cyc(3);
    check(level == 1'b1, "R3 zero count rise", level, 1);
    pad = 0; cyc(3);
    check(level == 1'b0, "R3 zero count fall", level, 0);

    // R4/R6 thresholds in reject-both mode
    setup(4'd3, 1'b0, 1'b0, 2'b01);
    count_to_change(1'b1, 100, n); check(n == 6, "R4 R6 rise 3x2", n, 6);
    count_to_change(1'b0, 100, n); check(n == 6, "R4 R6 fall 3x2", n, 6);
    setup(4'd15, 1'b0, 1'b0, 2'b01);
    count_to_change(1'b1, 100, n); check(n == 30, "R6 15x2", n, 30);
    setup(4'd2, 1'b0, 1'b1, 2'b01);
    count_to_change(1'b0, 100, n); check(n == 16, "R6 2x8", n, 16);
    setup(4'd1, 1'b1, 1'b0, 2'b01);
    count_to_change(1'b1, 3000, n); check(n == 512, "R6 1x512", n, 512);
    setup(4'd1, 1'b1, 1'b1, 2'b01);
    count_to_change(1'b0, 3000, n); check(n == 2048, "R6 1x2048", n, 2048);

    // R5 short return discards progress
    setup(4'd3, 1'b0, 1'b0, 2'b01);
    pad = 1; cyc(3); give_ticks(4);
    check(level == 1'b0, "R5 still old after partial ticks", level, 0);
    pad = 0; cyc(1); pad = 1;
    count_to_change(1'b1, 100, n); check(n == 6, "R5 full restart", n, 6);

    // R10 no tick, no change
    setup(4'd1, 1'b0, 1'b0, 2'b01);
    pad = 0; cyc(60);
    check(level == 1'b1, "R10 holds without tick", level, 1);
    give_ticks(2);
    check(level == 1'b0, "R10 changes after ticks", level, 0);

    // R7 keep low pulses
    setup(4'd2, 1'b0, 1'b0, 2'b10);
    count_to_change(1'b1, 100, n); check(n == 4, "R7 rise filtered", n, 4);
    count_to_change(1'b0, 100, n); check(n == 0, "R7 fall immediate", n, 0);
    // R8 keep high pulses
    setup(4'd2, 1'b0, 1'b0, 2'b11);
    count_to_change(1'b1, 100, n); check(n == 0, "R8 rise immediate", n, 0);
    count_to_change(1'b0, 100, n); check(n == 4, "R8 fall filtered", n, 4);

    // random phase against the model
    cyc(2);
    cmp_en = 1;
    void'($urandom(32'd1234));
    for (int blk = 0; blk < 20; blk++) begin
      setup(4'($urandom % 16), 1'b0, 1'($urandom % 2), 2'($urandom % 4));
      for (int c = 0; c < 200;) begin
        int hold = 1 + ($urandom % 40);
        pad = 1'($urandom % 2);
        for (int k = 0; k < hold; k++) begin
          tick = ($urandom % 3) == 0;
          @(negedge clk);
        end
        tick = 0;
        c += hold;
      end
    end
    cmp_en = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule